// File: doc/BRIEF.md
# Flash Status Register and Write-Protection Unit

This block holds the protection state of a serial NOR flash: a write-enable latch, three block-protect bits and a status-register lock bit. An upstream command decoder hands it one decoded command per cycle, together with a byte address and, for status writes, a data byte. The block replies one cycle later with an accept or reject flag and updates its state in the same clock edge. The array, the serial shifter and the program/erase timing sit outside. A busy input from the program/erase sequencer freezes everything except status reads.

Status writes are gated by the lock bit and the active-low write-protect pin together. When both are asserted, the status register is hardware-locked. The lock can be entered in either order and is left only by raising the pin. The block-protect bits select an upper part of the array that program and erase may not touch.

Top module: `flash_wp_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the lock bit, the block-protect bits and the write-enable latch are 0 and resp_valid is 0.
- R2: Command codes are 0 none, 1 set-latch, 2 clear-latch, 3 status-write, 4 status-read, 5 page-program, 6 sector-erase, 7 bulk-erase. Set-latch sets the write-enable latch and clear-latch clears it; both are accepted. Command 0 produces no response.
- R3: While the lock bit is 0, a status-write with the latch set is accepted at either pin level. It loads the lock bit from data bit 7 and the block-protect bits from data bits 4:2.
- R4: While the lock bit is 1 and wp_n is high, a status-write with the latch set is accepted.
- R5: While the lock bit is 1 and wp_n is low, every status-write is rejected and leaves the lock and block-protect bits unchanged. This holds whichever of the two conditions came first, and it ends only when wp_n returns high.
- R6: Block-protect value n (1 to 7) protects the upper min(2^(n-1), 8) of the eight 64 KiB sectors; value 0 protects nothing. The sector is address bits 18:16. A page-program or sector-erase is accepted only if the latch is set and the sector is unprotected.
- R7: A bulk-erase is rejected whenever any block-protect bit is 1. Otherwise it is accepted if the latch is set.
- R8: Any status-write, page-program, sector-erase or bulk-erase that is not blocked by busy clears the write-enable latch, whether it is accepted or rejected. Such a request made with the latch clear is rejected.
- R9: A status-read is always accepted, even while busy. status_byte always shows {lock, 0, 0, bp[2:0], latch, busy}, with the lock bit in bit 7.
- R10: While busy is high, every command other than status-read gets resp_valid with resp_accept 0 and changes no state.
- R11: A response for a command presented at one clock edge appears as resp_valid and resp_accept after that edge and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | 19 | Byte address for program and sector erase |
| cmd_wdata | input | 8 | New status byte for a status-write |
| wp_n | input | 1 | Active-low write-protect pin (synchronous to clk) |
| busy | input | 1 | Program or erase in progress |
| resp_valid | output | 1 | Response present |
| resp_accept | output | 1 | 1 accepted, 0 rejected |
| status_byte | output | 8 | Current status byte (see R9) |

## Verification
On every cycle, the embedded assertions check four things. The lock keeps the status bits stable against status-writes while the pin is low. Bulk-erase and requests made without the latch are never accepted. The latch clears after every write-type request. Busy blocks all state changes. The bench shows the rest, which depends on history. Its scenarios enter the hardware lock in both orders and leave it by raising the pin. They cover the exact sector boundaries of each block-protect value. A fixed-seed random command stream, compared with a reference model, checks that the accept flag and the status byte agree over long mixed histories.

// File: rtl/flash_wp_pkg.sv
// Shared command codes and status-byte field positions for the write-protection unit.
package flash_wp_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_WEN  = 3'd1,
        OP_WDIS = 3'd2,
        OP_SRWR = 3'd3,
        OP_SRRD = 3'd4,
        OP_PROG = 3'd5,
        OP_SERS = 3'd6,
        OP_BERS = 3'd7
    } wp_op_e;

    localparam int LOCK_POS = 7;
    localparam int BP_LSB   = 2;
    localparam int BP_W     = 3;
endpackage

// File: rtl/wp_region_check.sv
// Decides whether an address falls in the top-of-array region selected by the
// block-protect code. Assumes sectors are 2^SECTOR_W bytes and the region doubles
// per code step starting at one sector, capped at the whole array.
module wp_region_check #(
    parameter int ADDR_W   = 19,
    parameter int SECTOR_W = 16,
    parameter int BP_W     = 3
) (
    input  logic [BP_W-1:0]   bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_prot,
    output logic              any_prot
);
    localparam int SECT_BITS = ADDR_W - SECTOR_W;
    localparam int CNT_W     = SECT_BITS + 1;
    localparam logic [CNT_W-1:0] NUM_SECT = CNT_W'(1) << SECT_BITS;

    logic [CNT_W-1:0] prot_cnt;
    logic [CNT_W-1:0] sect;

    // Number of protected sectors for the current code.
    always_comb begin
        if (bp == '0)
            prot_cnt = '0;
        else if (int'(bp) - 1 >= SECT_BITS)
            prot_cnt = NUM_SECT;
        else
            prot_cnt = CNT_W'(1) << (bp - 1'b1);
    end

    // Compare the sector index of the address with the region's lower bound.
    always_comb begin
        sect     = {1'b0, addr[ADDR_W-1:SECTOR_W]};
        in_prot  = (sect >= (NUM_SECT - prot_cnt));
        any_prot = (bp != '0);
    end
endmodule

// File: rtl/wp_cmd_decide.sv
// Pure decision logic: given the command and current protection state, returns
// whether a response is produced, whether it is accepted, and which state updates apply.
// Assumes wp_n is already synchronous to the clock.
module wp_cmd_decide
    import flash_wp_pkg::*;
(
    input  logic [2:0] op,
    input  logic       busy,
    input  logic       wel,
    input  logic       lock,
    input  logic       wp_n,
    input  logic       in_prot,
    input  logic       any_prot,
    output logic       rsp,
    output logic       acc,
    output logic       wel_set,
    output logic       wel_clr,
    output logic       sr_wr
);
    // Map each command onto accept flag and state-update strobes.
    always_comb begin
        rsp     = 1'b1;
        acc     = 1'b0;
        wel_set = 1'b0;
        wel_clr = 1'b0;
        sr_wr   = 1'b0;
        if (op == OP_NONE) begin
            rsp = 1'b0;
        end else if (op == OP_SRRD) begin
            acc = 1'b1;
        end else if (!busy) begin
            case (op)
                OP_WEN:  begin acc = 1'b1; wel_set = 1'b1; end
                OP_WDIS: begin acc = 1'b1; wel_clr = 1'b1; end
                OP_SRWR: begin
                    wel_clr = 1'b1;
                    acc     = wel && (!lock || wp_n);
                    sr_wr   = acc;
                end
                OP_PROG, OP_SERS: begin
                    wel_clr = 1'b1;
                    acc     = wel && !in_prot;
                end
                OP_BERS: begin
                    wel_clr = 1'b1;
                    acc     = wel && !any_prot;
                end
                default: acc = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/wp_status_regs.sv
// Holds the lock bit, block-protect bits and write-enable latch. Updates come as
// strobes from the decision logic; a set strobe wins over a clear strobe.
module wp_status_regs
    import flash_wp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wel_set,
    input  logic            wel_clr,
    input  logic            sr_wr,
    input  logic [7:0]      sr_data,
    output logic            wel,
    output logic            lock,
    output logic [BP_W-1:0] bp
);
    // Write-enable latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel <= 1'b0;
        else if (wel_set) wel <= 1'b1;
        else if (wel_clr) wel <= 1'b0;
    end

    // Lock and block-protect bits, loaded only on an accepted status-write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b0;
            bp   <= '0;
        end else if (sr_wr) begin
            lock <= sr_data[LOCK_POS];
            bp   <= sr_data[BP_LSB +: BP_W];
        end
    end

    AST_NO_SET_CLR_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(wel_set && wel_clr)); // R2
endmodule

// File: rtl/flash_wp_unit.sv
// Top of the write-protection unit: ties region check, decision and state together
// and registers a one-cycle response. Assumes one decoded command per cycle.
module flash_wp_unit
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int SECTOR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    input  logic              wp_n,
    input  logic              busy,
    output logic              resp_valid,
    output logic              resp_accept,
    output logic [7:0]        status_byte
);
    logic [2:0]      op_eff;
    logic            in_prot, any_prot;
    logic            rsp, acc, wel_set, wel_clr, sr_wr;
    logic            wel, lock;
    logic [BP_W-1:0] bp;

    assign op_eff = cmd_valid ? cmd_op : 3'(OP_NONE);

    wp_region_check #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .BP_W(BP_W)) u_region (
        .bp(bp), .addr(cmd_addr), .in_prot(in_prot), .any_prot(any_prot)
    );

    wp_cmd_decide u_decide (
        .op(op_eff), .busy(busy), .wel(wel), .lock(lock), .wp_n(wp_n),
        .in_prot(in_prot), .any_prot(any_prot),
        .rsp(rsp), .acc(acc), .wel_set(wel_set), .wel_clr(wel_clr), .sr_wr(sr_wr)
    );

    wp_status_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
        .sr_wr(sr_wr), .sr_data(cmd_wdata), .wel(wel), .lock(lock), .bp(bp)
    );

    // One-cycle response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_accept <= 1'b0;
        end else begin
            resp_valid  <= rsp;
            resp_accept <= rsp && acc;
        end
    end

    // Status byte view.
    assign status_byte = {lock, 2'b00, bp, wel, busy};

    AST_LOCK_HOLDS_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SRWR && lock && !wp_n)
        |=> ($stable(lock) && $stable(bp) && !resp_accept)); // R5
    AST_BULK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_BERS && bp != '0) |=> !resp_accept); // R7
    AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op == OP_SRWR || cmd_op == OP_PROG ||
         cmd_op == OP_SERS || cmd_op == OP_BERS)) |=> !wel); // R8
    AST_NO_LATCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wel && (cmd_op == OP_SRWR || cmd_op == OP_PROG ||
         cmd_op == OP_SERS || cmd_op == OP_BERS)) |=> !resp_accept); // R8
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy && cmd_op != OP_SRRD && cmd_op != OP_NONE)
        |=> ($stable(lock) && $stable(bp) && $stable(wel) && resp_valid && !resp_accept)); // R10
    AST_READ_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SRRD) |=> (resp_valid && resp_accept)); // R9
endmodule

// File: tb/tb_flash_wp_unit.sv
module tb_flash_wp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [18:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        wp_n = 1'b1;
    logic        busy = 1'b0;
    logic        resp_valid, resp_accept;
    logic [7:0]  status_byte;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic       m_lock = 0, m_wel = 0;
    logic [2:0] m_bp = 0;

    always #2 clk = ~clk;

    flash_wp_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n), .busy(busy),
        .resp_valid(resp_valid), .resp_accept(resp_accept), .status_byte(status_byte)
    );

    function automatic logic prot(input logic [2:0] bp, input logic [18:0] a);
        int cnt;
        if (bp == 0) cnt = 0;
        else begin
            cnt = 1 << (bp - 1);
            if (cnt > 8) cnt = 8;
        end
        return int'(a[18:16]) >= 8 - cnt;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue a command, advance the model, check response and status.
    task automatic step(input logic [2:0] op, input logic [18:0] a, input logic [7:0] d,
                        input logic bz, input logic wp, input string req);
        logic exp_acc, exp_rsp;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; busy = bz; wp_n = wp;
        exp_rsp = (op != 0);
        exp_acc = 1'b0;
        if (op == 4) exp_acc = 1'b1;
        else if (op != 0 && !bz) begin
            case (op)
                1: begin exp_acc = 1; m_wel = 1; end
                2: begin exp_acc = 1; m_wel = 0; end
                3: begin
                    exp_acc = m_wel && (!m_lock || wp);
                    if (exp_acc) begin m_lock = d[7]; m_bp = d[4:2]; end
                    m_wel = 0;
                end
                5, 6: begin exp_acc = m_wel && !prot(m_bp, a); m_wel = 0; end
                7: begin exp_acc = m_wel && (m_bp == 0); m_wel = 0; end
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        check({req, " resp_valid R11"}, 32'(resp_valid), 32'(exp_rsp));
        if (exp_rsp) check({req, " accept"}, 32'(resp_accept), 32'(exp_acc));
        check({req, " status R9"}, 32'(status_byte), 32'({m_lock, 2'b00, m_bp, m_wel, bz}));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 resp_valid", 32'(resp_valid), 0);
        check("R1 status", 32'(status_byte), 0);
        rst_n = 1'b1;

        // R2 latch set/clear, R11 no response on code 0
        step(1, 0, 0, 0, 1, "R2 set");
        step(2, 0, 0, 0, 1, "R2 clear");
        step(0, 0, 0, 0, 1, "R11 none");
        // R8 write without latch
        step(5, 19'h00000, 0, 0, 1, "R8 nolatch prog");
        // R3 status write with pin low, lock 0
        step(1, 0, 0, 0, 0, "R3 set");
        step(3, 0, 8'h04, 0, 0, "R3 write bp1 pin low");
        // R6 bp=1 -> sector 7 protected, 6 not
        step(1, 0, 0, 0, 1, "R6 set");
        step(5, 19'h70000, 0, 0, 1, "R6 prog sector7");
        step(1, 0, 0, 0, 1, "R6 set");
        step(6, 19'h6FFFF, 0, 0, 1, "R6 erase sector6");
        // R7 bulk erase with bp != 0
        step(1, 0, 0, 0, 1, "R7 set");
        step(7, 0, 0, 0, 1, "R7 bulk");
        // R4 lock=1 pin high accepted; order A: set bit then pin low
        step(1, 0, 0, 0, 1, "R4 set");
        step(3, 0, 8'h88, 0, 1, "R4 write lock bp2");
        step(1, 0, 0, 0, 0, "R5 set pin low");
        step(3, 0, 8'h00, 0, 0, "R5 locked write");
        step(4, 0, 0, 0, 0, "R5 read");
        step(1, 0, 0, 0, 1, "R5 set pin high");
        step(3, 0, 8'h00, 0, 1, "R5 exit write");
        // order B: pin low first, then set lock
        step(1, 0, 0, 0, 0, "R5 set B");
        step(3, 0, 8'h9C, 0, 0, "R5 lock with pin low");
        step(1, 0, 0, 0, 0, "R5 set B2");
        step(3, 0, 8'h00, 0, 0, "R5 locked B");
        // R6 bp=7 whole array protected
        step(1, 0, 0, 0, 0, "R6 set");
        step(5, 19'h00000, 0, 0, 0, "R6 prog sector0 bp7");
        // R10 busy ignores
        step(1, 0, 0, 1, 1, "R10 busy set");
        step(4, 0, 0, 1, 1, "R10 busy read R9");
        step(1, 0, 0, 0, 1, "R10 set");
        step(3, 0, 8'h00, 1, 1, "R10 busy write");
        step(3, 0, 8'h00, 0, 1, "R3 clear all");
        step(1, 0, 0, 0, 1, "R7 set");
        step(7, 0, 0, 0, 1, "R7 bulk bp0");

        // Random mix
        for (int i = 0; i < 800; i++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 2) == 0) op = 3'd1;
            step(op, 19'($urandom), 8'($urandom), $urandom_range(0, 7) == 0,
                 $urandom_range(0, 3) != 0, "R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule